// File: doc/BRIEF.md
# Tiled 8x8 Integer Matrix Multiply-Accumulate Sequencer

This block forms the 8x8 product D = A x B of two signed 16-bit matrices held in its own operand storage. Each operand is seen as four 4x4 quadrants. Each output quadrant is built from two 4x4 tile multiply-accumulate steps of the form D = A x B + C. The first step starts from a cleared accumulator. The second step takes the first step's 32-bit partial tile straight from a local accumulator bank as its C input. That partial tile is never written into operand storage.

Software loads A and B one element per cycle through the load port, then pulses `start`. The sequencer walks the output quadrants in a fixed order: top-left, top-right, bottom-left, bottom-right. One dot-product datapath of four multipliers produces one tile element per cycle. The final sums go into a result store that the read port exposes combinationally.

The control state machine has five states:
- IDLE waits for `start`; IDLE to CLEAR on `start`.
- CLEAR zeroes the accumulator bank; CLEAR to PASS0 always.
- PASS0 runs the first tile step of the current quadrant; PASS0 to PASS1 after element 15.
- PASS1 runs the second tile step and writes results; PASS1 to CLEAR after element 15 of quadrants 0 to 2, and PASS1 to DONE after element 15 of quadrant 3.
- DONE raises `done`; DONE to IDLE always.

Top module: `tmac_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, and every result element on the read port is 0.
- R2: A `start` sampled high at a clock edge while in IDLE makes `busy` high from that edge on. `busy` stays high until the edge after `done`.
- R3: `done` is high for exactly one cycle, in the cycle that begins 132 clock edges after the edge that captured `start`. At the next edge `busy` goes low.
- R4: A `start` seen while `busy` is high is ignored. The running computation keeps its timing and `done` pulses once only.
- R5: A load with `ld_en` high writes `ld_data` into A when `ld_sel` is 0, or into B when `ld_sel` is 1, at row `ld_row` and column `ld_col`. Loads while `busy` is high are ignored.
- R6: Each result element at row r and column c equals the sum over k = 0..7 of A[r][k] x B[k][c]. The operands are signed 16-bit values and the products and sums are formed in 32-bit two's complement with wraparound and no saturation.
- R7: Each output quadrant is formed as (A row-half, left) x (B top, column-half) plus (A row-half, right) x (B bottom, column-half). The first step's partial sum is carried to the second step in the accumulator bank, and the bank is cleared before every quadrant. As a result, no quadrant's value leaks into another quadrant or into another run.
- R8: `rd_data` shows the result element at `rd_row`, `rd_col` combinationally. Results stay unchanged after `done` until the next run writes them, even if A and B are reloaded in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a product; acted on only in IDLE |
| busy | output | 1 | High from start capture through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Operand write strobe |
| ld_sel | input | 1 | 0 selects A, 1 selects B |
| ld_row | input | 3 | Operand row index |
| ld_col | input | 3 | Operand column index |
| ld_data | input | 16 | Signed operand element |
| rd_row | input | 3 | Result row index |
| rd_col | input | 3 | Result column index |
| rd_data | output | 32 | Signed result element |

## Verification
The hardest situation to reach from the ports is a `start` and an operand write arriving in the middle of a run. That scenario checks that neither one disturbs the run nor lands in storage. The bench raises both during a run at a point where the written element has already been consumed. It then checks that `done` fires once at its normal cycle, and runs the product again so that a write that was wrongly accepted would show up in the results. Accumulator leakage between quadrants and between runs is exposed by back-to-back runs with data that differs in every quadrant, plus an extreme-value run whose sums wrap to zero.

// File: rtl/tmac_pkg.sv
package tmac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_PASS0,
        ST_PASS1,
        ST_DONE
    } tmac_state_e;

endpackage

// File: rtl/tmac_opstore.sv
module tmac_opstore #(
    parameter int DW = 16,
    parameter int N  = 8,
    parameter int T  = 4,
    parameter int IW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 sel,
    input  logic [IW-1:0]        row,
    input  logic [IW-1:0]        col,
    input  logic signed [DW-1:0] wdata,
    input  logic [IW-1:0]        a_row,
    input  logic [IW-1:0]        b_col,
    input  logic [IW-1:0]        k_base,
    output logic signed [DW-1:0] a_vec [T],
    output logic signed [DW-1:0] b_vec [T]
);

    logic signed [DW-1:0] a_mem [N][N];
    logic signed [DW-1:0] b_mem [N][N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) begin
                for (int c = 0; c < N; c++) begin
                    a_mem[r][c] <= '0;
                    b_mem[r][c] <= '0;
                end
            end
        end else if (we) begin
            if (sel) b_mem[row][col] <= wdata;
            else     a_mem[row][col] <= wdata;
        end
    end

    // one row slice of A and one column slice of B per cycle
    for (genvar g = 0; g < T; g++) begin : g_tap
        assign a_vec[g] = a_mem[a_row][k_base + IW'(g)];
        assign b_vec[g] = b_mem[k_base + IW'(g)][b_col];
    end

endmodule

// File: rtl/tmac_dot.sv
module tmac_dot #(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int T  = 4
) (
    input  logic signed [DW-1:0] a_vec [T],
    input  logic signed [DW-1:0] b_vec [T],
    input  logic signed [AW-1:0] c_in,
    output logic signed [AW-1:0] d_out
);

    logic signed [AW-1:0] prod [T];

    for (genvar g = 0; g < T; g++) begin : g_mul
        assign prod[g] = AW'(a_vec[g]) * AW'(b_vec[g]);
    end

    always_comb begin
        d_out = c_in;
        for (int g = 0; g < T; g++) begin
            d_out = d_out + prod[g];
        end
    end

endmodule

// File: rtl/tmac_resstore.sv
module tmac_resstore #(
    parameter int AW = 32,
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IW-1:0]        wrow,
    input  logic [IW-1:0]        wcol,
    input  logic signed [AW-1:0] wdata,
    input  logic [IW-1:0]        rrow,
    input  logic [IW-1:0]        rcol,
    output logic signed [AW-1:0] rdata
);

    logic signed [AW-1:0] mem [N][N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) begin
                for (int c = 0; c < N; c++) begin
                    mem[r][c] <= '0;
                end
            end
        end else if (we) begin
            mem[wrow][wcol] <= wdata;
        end
    end

    assign rdata = mem[rrow][rcol];

endmodule

// File: rtl/tmac_seq.sv
module tmac_seq
    import tmac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int T  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    output logic                        busy,
    output logic                        done,
    input  logic                        ld_en,
    input  logic                        ld_sel,
    input  logic [$clog2(2*T)-1:0]      ld_row,
    input  logic [$clog2(2*T)-1:0]      ld_col,
    input  logic signed [DW-1:0]        ld_data,
    input  logic [$clog2(2*T)-1:0]      rd_row,
    input  logic [$clog2(2*T)-1:0]      rd_col,
    output logic signed [AW-1:0]        rd_data
);

    localparam int N  = 2 * T;
    localparam int IW = $clog2(N);
    localparam int TW = $clog2(T);
    localparam int EW = 2 * TW;
    localparam int NE = T * T;

    tmac_state_e state_q, state_d;
    logic [EW-1:0] e_q;
    logic [1:0]    q_q;
    logic          last_e, acc_clr, mac_en, res_we, pass_hi;

    logic [TW-1:0] ei, ej;
    logic [IW-1:0] a_row, b_col, k_base;
    logic signed [DW-1:0] a_vec [T];
    logic signed [DW-1:0] b_vec [T];
    logic signed [AW-1:0] acc [NE];
    logic signed [AW-1:0] dot_out;

    assign last_e = (e_q == EW'(NE - 1));
    assign ei     = e_q[EW-1:TW];
    assign ej     = e_q[TW-1:0];
    assign a_row  = {q_q[1], ei};
    assign b_col  = {q_q[0], ej};
    assign k_base = {pass_hi, {TW{1'b0}}};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_PASS0;
            ST_PASS0: if (last_e) state_d = ST_PASS1;
            ST_PASS1: if (last_e) state_d = (q_q == 2'd3) ? ST_DONE : ST_CLEAR;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        acc_clr = 1'b0;
        mac_en  = 1'b0;
        res_we  = 1'b0;
        pass_hi = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_CLEAR: acc_clr = 1'b1;
            ST_PASS0: mac_en = 1'b1;
            ST_PASS1: begin
                mac_en  = 1'b1;
                res_we  = 1'b1;
                pass_hi = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // element and quadrant counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
            q_q <= '0;
        end else begin
            e_q <= mac_en ? e_q + 1'b1 : '0;
            if (!busy)                q_q <= '0;
            else if (res_we && last_e) q_q <= q_q + 1'b1;
        end
    end

    // forwarded accumulator tile: C of the second step is D of the first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) acc[i] <= '0;
        end else if (acc_clr) begin
            for (int i = 0; i < NE; i++) acc[i] <= '0;
        end else if (mac_en) begin
            acc[e_q] <= dot_out;
        end
    end

    tmac_opstore #(.DW(DW), .N(N), .T(T), .IW(IW)) u_ops (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ld_en && !busy),
        .sel    (ld_sel),
        .row    (ld_row),
        .col    (ld_col),
        .wdata  (ld_data),
        .a_row  (a_row),
        .b_col  (b_col),
        .k_base (k_base),
        .a_vec  (a_vec),
        .b_vec  (b_vec)
    );

    tmac_dot #(.DW(DW), .AW(AW), .T(T)) u_dot (
        .a_vec (a_vec),
        .b_vec (b_vec),
        .c_in  (acc[e_q]),
        .d_out (dot_out)
    );

    tmac_resstore #(.AW(AW), .N(N), .IW(IW)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (res_we),
        .wrow  (a_row),
        .wcol  (b_col),
        .wdata (dot_out),
        .rrow  (rd_row),
        .rcol  (rd_col),
        .rdata (rd_data)
    );

endmodule

// File: rtl/tmac_seq_chk.sv
module tmac_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic res_we,
    input logic acc_clr
);

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    // R7
    clr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> acc_clr);

    // R8
    write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (busy && !done));

endmodule

bind tmac_seq tmac_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .res_we  (res_we),
    .acc_clr (acc_clr)
);

// File: tb/tb_tmac_seq.sv
`timescale 1ns/1ps
module tb_tmac_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done;
    logic ld_en = 1'b0, ld_sel = 1'b0;
    logic [2:0] ld_row = '0, ld_col = '0, rd_row = '0, rd_col = '0;
    logic signed [15:0] ld_data = '0;
    logic signed [31:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    shortint ma [8][8];
    shortint mb [8][8];
    int      md [8][8];

    always #4 clk = ~clk;

    tmac_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_row(ld_row), .ld_col(ld_col),
        .ld_data(ld_data), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void calc_ref();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                int s = 0;
                for (int k = 0; k < 8; k++) s = s + int'(ma[r][k]) * int'(mb[k][c]);
                md[r][c] = s;
            end
    endfunction

    task automatic load_all();
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++) begin
                    @(negedge clk);
                    ld_en = 1'b1; ld_sel = s[0]; ld_row = 3'(r); ld_col = 3'(c);
                    ld_data = (s == 0) ? ma[r][c] : mb[r][c];
                end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                rd_row = 3'(r); rd_col = 3'(c);
                #1;
                check(rd_data == md[r][c], req, rd_data, md[r][c]);
            end
    endtask

    // runs one product; checks R2 busy, R3 done timing and busy release
    task automatic run_once(input string req);
        int cnt = 0;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        while (!done && cnt < 1000) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (!done && !busy) break;
        end
        check(cnt == 132, {"R3 done latency ", req}, cnt, 132);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R3 done one cycle, busy low", {done, busy}, 0);
    endtask

    task automatic t_reset();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) md[r][c] = 0;
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        read_all("R1 result cleared");
    endtask

    task automatic t_identity();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                ma[r][c] = (r == c) ? 16'sd1 : 16'sd0;
                mb[r][c] = shortint'(r * 8 + c - 20);
            end
        calc_ref();
        load_all();
        run_once("identity");
        read_all("R6 identity times B");
    endtask

    task automatic t_mixed();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                ma[r][c] = shortint'((r * 3 - c * 5 + 1) * 37);
                mb[r][c] = shortint'((c * 7 - r * 2 - 3) * 53);
            end
        calc_ref();
        load_all();
        run_once("mixed");
        read_all("R7 quadrant forwarding mixed data");
    endtask

    task automatic t_extreme();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                ma[r][c] = -16'sd32768;
                mb[r][c] = (c < 4) ? -16'sd32768 : 16'sd32767;
            end
        calc_ref();
        load_all();
        run_once("extreme");
        read_all("R6 wraparound extremes");
        rd_row = 3'd2; rd_col = 3'd1; #1;
        check(rd_data == 0, "R6 wrap to zero", rd_data, 0);
    endtask

    // start and load during a run must not disturb anything
    task automatic t_busy_ignore();
        int cnt = 0;
        int pulses = 0;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                ma[r][c] = shortint'(r - c + 2);
                mb[r][c] = shortint'(r * c - 7);
            end
        calc_ref();
        load_all();
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        while (!done && cnt < 1000) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (cnt == 40) begin
                start = 1'b1; ld_en = 1'b1; ld_sel = 1'b0;
                ld_row = 3'd0; ld_col = 3'd0; ld_data = 16'sd999;
            end else begin
                start = 1'b0; ld_en = 1'b0;
            end
            if (!done && !busy) break;
        end
        check(cnt == 132, "R4 timing kept despite start", cnt, 132);
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (done) pulses++;
        end
        check(pulses == 0, "R4 no second done", pulses, 0);
        check(busy == 1'b0, "R4 idle after run", busy, 0);
        read_all("R4 results of undisturbed run");
        run_once("rerun");
        read_all("R5 load during busy ignored");
    endtask

    task automatic t_load_select();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                ma[r][c] = 16'sd0;
                mb[r][c] = 16'sd0;
            end
        ma[5][2] = 16'sd3;
        mb[2][6] = -16'sd11;
        calc_ref();
        load_all();
        run_once("select");
        read_all("R5 A/B select and index");
        rd_row = 3'd5; rd_col = 3'd6; #1;
        check(rd_data == -33, "R5 single element product", rd_data, -33);
    endtask

    // results hold after done, even across operand reloads
    task automatic t_hold();
        repeat (30) @(negedge clk);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                ma[r][c] = 16'sd77;
                mb[r][c] = 16'sd5;
            end
        load_all();
        repeat (10) @(negedge clk);
        read_all("R8 results hold after reload");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_mixed();
        t_extreme();
        t_busy_ignore();
        t_load_select();
        t_hold();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule